// File: doc/BRIEF.md
# Image Row Memory Transfer Scheduler

This block shares a single wide memory user port between two jobs. The first job takes image rows from an input staging buffer and writes them into external memory. The second job starts once a complete image is resident in memory: it reads that image back, row by row, and streams it to a downstream buffer. Work is scheduled one whole row at a time. Between rows the scheduler always gives a waiting input row the port before any read.

The scheduler drives a command channel and a write-data channel, each with a ready handshake. A pending command and its write data are held unchanged until the memory side accepts them. Read data comes back in issue order after a variable delay and is passed straight on to the downstream buffer. The downstream side reports two things: a full flag, and the number of beats of free space it has. The scheduler never has more reads in flight than that free space can take. It also issues nothing at all until the memory reports that calibration is complete.

Memory is used as a ring of image slots, addressed in beats. A slot is never overwritten before its image has been read out.

Top module: `row_xfer_sched`

## Requirements
- R1: While reset is asserted, `memEn`, `memWdfWren`, `inPop` and `outValid` are low.
- R2: No new command is presented while `calDone` is low.
- R3: A presented command keeps `memEn`, `memAddr` and `memCmd` unchanged until the cycle in which `memRdy` is high. Write data keeps `memWdfWren` and `memWdfData` unchanged until the cycle in which `memWdfRdy` is high.
- R4: Command codes are 3'b000 for write and 3'b001 for read. Addresses count 512-bit beats. Write addresses and read addresses each start at 0 and step by one per command, wrapping after BEATS_PER_ROW*ROWS_PER_IMG*IMG_SLOTS beats.
- R5: The beats on `outData` match the beats taken from the staging buffer, one for one and in the same order.
- R6: A read command is accepted only for an image whose every beat, both command and data, has already been accepted by the memory.
- R7: Writes have priority. While a full input row waits and an image slot is free, at most BEATS_PER_ROW read commands are issued before the next write command.
- R8: No beat address is written again before it has been read.
- R9: No new read command appears in the cycle after `outFull` was high. While the downstream buffer is full, the scheduler waits in a hold state.
- R10: Reads in flight plus beats already delivered never exceed the free space that `dnSpace` reported, so the downstream buffer cannot overflow.
- R11: Single-write mode. Every new write command is presented in the same cycle as its write data, with `memWdfEnd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calDone | input | 1 | Memory calibration complete |
| inRowReady | input | 1 | Staging buffer holds at least one full row |
| inData | input | DATA_W | Head beat of the staging buffer (first-word fall-through) |
| inPop | output | 1 | Consume the head staging beat |
| memAddr | output | ADDR_W | Command beat address |
| memCmd | output | 3 | Command code |
| memEn | output | 1 | Command valid |
| memRdy | input | 1 | Command accepted this cycle |
| memWdfData | output | DATA_W | Write data |
| memWdfWren | output | 1 | Write data valid |
| memWdfEnd | output | 1 | Last beat of write burst |
| memWdfRdy | input | 1 | Write data accepted this cycle |
| memRdData | input | DATA_W | Returned read data |
| memRdValid | input | 1 | Returned read data valid |
| outData | output | DATA_W | Beat to downstream buffer |
| outValid | output | 1 | Downstream beat valid |
| outFull | input | 1 | Downstream buffer full |
| dnSpace | input | SPACE_W | Free beats in downstream buffer |

## Verification
A wrong count of beats, rows or images in the controller shows up quickly at the ports. A write or read address breaks its sequence at the very next accepted command. A read of an image that is not yet complete, or an overwrite of an unread slot, is caught when that command is accepted. A mistake in the read-credit counter or the full handling is seen within a few cycles as an overfilled downstream buffer or a read issued just after full. Lost or reordered data is caught beat by beat when the output stream is compared against the staged input.

// File: rtl/row_xfer_pkg.sv
package row_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_HOLD  = 2'd3
  } schedState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic issueWr;
    logic issueRd;
  } schedStrobe_t;

  localparam logic [2:0] CMD_WRITE = 3'b000;
  localparam logic [2:0] CMD_READ  = 3'b001;

endpackage

// File: rtl/row_xfer_ctrl.sv
module row_xfer_ctrl
  import row_xfer_pkg::*;
#(
  parameter int BEATS_PER_ROW = 16,
  parameter int ROWS_PER_IMG  = 80,
  parameter int IMG_SLOTS     = 4,
  parameter int SPACE_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               calDone,
  input  logic               rowReady,
  input  logic               outFull,
  input  logic [SPACE_W-1:0] dnSpace,
  input  logic               cmdFree,
  input  logic               wdfFree,
  input  logic               wdfIdle,
  input  logic [SPACE_W-1:0] outstanding,
  output schedStrobe_t       strb
);

  localparam int BEAT_W = (BEATS_PER_ROW > 1) ? $clog2(BEATS_PER_ROW) : 1;
  localparam int ROW_W  = (ROWS_PER_IMG > 1) ? $clog2(ROWS_PER_IMG) : 1;
  localparam int IMG_W  = $clog2(IMG_SLOTS) + 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT  = BEAT_W'(BEATS_PER_ROW - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW   = ROW_W'(ROWS_PER_IMG - 1);
  localparam logic [IMG_W-1:0]  SLOT_LIMIT = IMG_W'(IMG_SLOTS);

  schedState_t       state, stateNxt;
  logic [BEAT_W-1:0] beatCnt;
  logic [ROW_W-1:0]  wrRow, rdRow;
  logic [IMG_W-1:0]  imgWr, imgRd, imgGap;
  logic              lastBeat, slotFree, resident, creditOk;

  assign lastBeat = (beatCnt == LAST_BEAT);
  assign imgGap   = imgWr - imgRd;
  assign slotFree = (imgGap < SLOT_LIMIT);
  assign resident = (imgGap != '0);
  assign creditOk = (outstanding < dnSpace);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (calDone) begin
          if (rowReady && slotFree)       stateNxt = ST_WRITE;
          else if (resident && wdfIdle)   stateNxt = ST_READ;
        end
      end
      ST_WRITE: begin
        if (calDone && cmdFree && wdfFree) begin
          strb.issueWr = 1'b1;
          if (lastBeat) stateNxt = ST_IDLE;
        end
      end
      ST_READ: begin
        if (outFull) begin
          stateNxt = ST_HOLD;
        end else if (calDone && cmdFree && creditOk) begin
          strb.issueRd = 1'b1;
          if (lastBeat) stateNxt = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!outFull) stateNxt = ST_READ;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      wrRow   <= '0;
      rdRow   <= '0;
      imgWr   <= '0;
      imgRd   <= '0;
    end else begin
      state <= stateNxt;
      if (strb.issueWr || strb.issueRd)
        beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
      if (strb.issueWr && lastBeat) begin
        if (wrRow == LAST_ROW) begin
          wrRow <= '0;
          imgWr <= imgWr + 1'b1;
        end else begin
          wrRow <= wrRow + 1'b1;
        end
      end
      if (strb.issueRd && lastBeat) begin
        if (rdRow == LAST_ROW) begin
          rdRow <= '0;
          imgRd <= imgRd + 1'b1;
        end else begin
          rdRow <= rdRow + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/row_xfer_dpath.sv
module row_xfer_dpath
  import row_xfer_pkg::*;
#(
  parameter int DATA_W        = 512,
  parameter int ADDR_W        = 28,
  parameter int BEATS_PER_ROW = 16,
  parameter int ROWS_PER_IMG  = 80,
  parameter int IMG_SLOTS     = 4,
  parameter int SPACE_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  schedStrobe_t       strb,
  input  logic [DATA_W-1:0]  inData,
  output logic               inPop,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [2:0]         memCmd,
  output logic               memEn,
  input  logic               memRdy,
  output logic [DATA_W-1:0]  memWdfData,
  output logic               memWdfWren,
  output logic               memWdfEnd,
  input  logic               memWdfRdy,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic               memRdValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outValid,
  output logic               cmdFree,
  output logic               wdfFree,
  output logic               wdfIdle,
  output logic [SPACE_W-1:0] outstanding
);

  localparam int REGION = BEATS_PER_ROW * ROWS_PER_IMG * IMG_SLOTS;
  localparam int PTR_W  = (REGION > 1) ? $clog2(REGION) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(REGION - 1);

  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [SPACE_W-1:0] rdInFlight;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign cmdFree     = !memEn || memRdy;
  assign wdfFree     = !memWdfWren || memWdfRdy;
  assign wdfIdle     = !memWdfWren;
  assign inPop       = strb.issueWr;
  assign outData     = memRdData;
  assign outValid    = memRdValid;
  assign outstanding = rdInFlight;

  // command channel: load on issue, drop on acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memEn   <= 1'b0;
      memCmd  <= CMD_WRITE;
      memAddr <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      if (strb.issueWr) begin
        memEn   <= 1'b1;
        memCmd  <= CMD_WRITE;
        memAddr <= ADDR_W'(wrPtr);
        wrPtr   <= stepPtr(wrPtr);
      end else if (strb.issueRd) begin
        memEn   <= 1'b1;
        memCmd  <= CMD_READ;
        memAddr <= ADDR_W'(rdPtr);
        rdPtr   <= stepPtr(rdPtr);
      end else if (memRdy) begin
        memEn <= 1'b0;
      end
    end
  end

  // write-data channel: presented together with the write command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWdfWren <= 1'b0;
      memWdfEnd  <= 1'b0;
      memWdfData <= '0;
    end else if (strb.issueWr) begin
      memWdfWren <= 1'b1;
      memWdfEnd  <= 1'b1;
      memWdfData <= inData;
    end else if (memWdfRdy) begin
      memWdfWren <= 1'b0;
      memWdfEnd  <= 1'b0;
    end
  end

  // reads in flight, bounded by downstream credit in the controller
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdInFlight <= '0;
    end else begin
      unique case ({strb.issueRd, memRdValid})
        2'b10:   rdInFlight <= rdInFlight + 1'b1;
        2'b01:   rdInFlight <= rdInFlight - 1'b1;
        default: rdInFlight <= rdInFlight;
      endcase
    end
  end

endmodule

// File: rtl/row_xfer_sched.sv
module row_xfer_sched
  import row_xfer_pkg::*;
#(
  parameter int DATA_W        = 512,
  parameter int ADDR_W        = 28,
  parameter int BEATS_PER_ROW = 16,
  parameter int ROWS_PER_IMG  = 80,
  parameter int IMG_SLOTS     = 4,
  parameter int SPACE_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               calDone,
  input  logic               inRowReady,
  input  logic [DATA_W-1:0]  inData,
  output logic               inPop,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [2:0]         memCmd,
  output logic               memEn,
  input  logic               memRdy,
  output logic [DATA_W-1:0]  memWdfData,
  output logic               memWdfWren,
  output logic               memWdfEnd,
  input  logic               memWdfRdy,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic               memRdValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outValid,
  input  logic               outFull,
  input  logic [SPACE_W-1:0] dnSpace
);

  schedStrobe_t       strb;
  logic               cmdFree, wdfFree, wdfIdle;
  logic [SPACE_W-1:0] outstanding;

  row_xfer_ctrl #(
    .BEATS_PER_ROW(BEATS_PER_ROW),
    .ROWS_PER_IMG (ROWS_PER_IMG),
    .IMG_SLOTS    (IMG_SLOTS),
    .SPACE_W      (SPACE_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .calDone    (calDone),
    .rowReady   (inRowReady),
    .outFull    (outFull),
    .dnSpace    (dnSpace),
    .cmdFree    (cmdFree),
    .wdfFree    (wdfFree),
    .wdfIdle    (wdfIdle),
    .outstanding(outstanding),
    .strb       (strb)
  );

  row_xfer_dpath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .BEATS_PER_ROW(BEATS_PER_ROW),
    .ROWS_PER_IMG (ROWS_PER_IMG),
    .IMG_SLOTS    (IMG_SLOTS),
    .SPACE_W      (SPACE_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inData     (inData),
    .inPop      (inPop),
    .memAddr    (memAddr),
    .memCmd     (memCmd),
    .memEn      (memEn),
    .memRdy     (memRdy),
    .memWdfData (memWdfData),
    .memWdfWren (memWdfWren),
    .memWdfEnd  (memWdfEnd),
    .memWdfRdy  (memWdfRdy),
    .memRdData  (memRdData),
    .memRdValid (memRdValid),
    .outData    (outData),
    .outValid   (outValid),
    .cmdFree    (cmdFree),
    .wdfFree    (wdfFree),
    .wdfIdle    (wdfIdle),
    .outstanding(outstanding)
  );

endmodule

// File: rtl/row_xfer_sched_chk.sv
module row_xfer_sched_chk
  import row_xfer_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rstN,
  input logic              calDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic [2:0]        memCmd,
  input logic              memEn,
  input logic              memRdy,
  input logic [DATA_W-1:0] memWdfData,
  input logic              memWdfWren,
  input logic              memWdfEnd,
  input logic              memWdfRdy,
  input logic              outFull
);

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memRdy) |=> (memEn && $stable(memAddr) && $stable(memCmd)));

  // R3
  wdf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWdfWren && !memWdfRdy) |=> (memWdfWren && $stable(memWdfData)));

  // R2
  cal_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!calDone && !memEn) |=> !memEn);

  // R9
  full_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memCmd == CMD_READ && (!$past(memEn) || $past(memRdy))) |-> !$past(outFull));

  // R11
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memCmd == CMD_WRITE && (!$past(memEn) || $past(memRdy)))
      |-> (memWdfWren && memWdfEnd));

endmodule

bind row_xfer_sched row_xfer_sched_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .calDone   (calDone),
  .memAddr   (memAddr),
  .memCmd    (memCmd),
  .memEn     (memEn),
  .memRdy    (memRdy),
  .memWdfData(memWdfData),
  .memWdfWren(memWdfWren),
  .memWdfEnd (memWdfEnd),
  .memWdfRdy (memWdfRdy),
  .outFull   (outFull)
);

// File: tb/row_xfer_sched_bench.sv
module row_xfer_sched_bench;
  import row_xfer_pkg::*;

  localparam int DW = 64, AW = 28, BPR = 4, RPI = 3, SLOTS = 2, SW = 4, CAP = 6;
  localparam int IMG_BEATS = BPR * RPI;
  localparam int REGION = IMG_BEATS * SLOTS;
  localparam int TOTAL_ROWS = 12;
  localparam int LIMIT = 20000;

  logic          clk = 1'b0, rstN = 1'b0, calDone = 1'b0, inRowReady = 1'b0;
  logic [DW-1:0] inData = '0, memRdData = '0;
  logic          memRdy = 1'b0, memWdfRdy = 1'b0, memRdValid = 1'b0, outFull = 1'b0;
  logic [SW-1:0] dnSpace = SW'(CAP);
  logic          inPop, memEn, memWdfWren, memWdfEnd, outValid;
  logic [AW-1:0] memAddr;
  logic [2:0]    memCmd;
  logic [DW-1:0] memWdfData, outData;

  always #4 clk = ~clk;

  row_xfer_sched #(
    .DATA_W(DW), .ADDR_W(AW), .BEATS_PER_ROW(BPR), .ROWS_PER_IMG(RPI),
    .IMG_SLOTS(SLOTS), .SPACE_W(SW)
  ) u_row_xfer_sched (
    .clk(clk), .rstN(rstN), .calDone(calDone), .inRowReady(inRowReady),
    .inData(inData), .inPop(inPop), .memAddr(memAddr), .memCmd(memCmd),
    .memEn(memEn), .memRdy(memRdy), .memWdfData(memWdfData),
    .memWdfWren(memWdfWren), .memWdfEnd(memWdfEnd), .memWdfRdy(memWdfRdy),
    .memRdData(memRdData), .memRdValid(memRdValid), .outData(outData),
    .outValid(outValid), .outFull(outFull), .dnSpace(dnSpace)
  );

  int errors = 0, checks = 0;
  logic [DW-1:0] stage[$], expQ[$], wDataQ[$], rdDataQ[$];
  int            wAddrQ[$], rdTimeQ[$];
  logic [DW-1:0] memArr[int];
  bit            live[int];
  int cyc = 0, fill = 0, wrNext = 0, rdNext = 0, stored = 0, rdAccCnt = 0;
  int pops = 0, rdLoads = 0, run = 0, received = 0, rowsPushed = 0, lastRdTime = 0;
  bit popPend = 0, prevEn = 0, prevAcc = 0, prevFull = 0, prevCond = 0;
  logic [AW-1:0] prevAddr = '0;
  logic [2:0]    prevCmd = '0;

  task automatic tally(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: stage a row and push its beats into the scoreboard
  task automatic pushRow();
    for (int b = 0; b < BPR; b++) begin
      logic [DW-1:0] d;
      d = {32'hA500_0000 + 32'(rowsPushed * BPR + b), ~32'(rowsPushed * 16 + b)};
      stage.push_back(d);
      expQ.push_back(d);
    end
    rowsPushed++;
  endtask

  // memory responder, downstream buffer and monitor
  initial begin
    @(posedge rstN);
    forever begin
      bit cond, newCmd, acc;
      int a, t;
      logic [DW-1:0] e;
      @(negedge clk);
      if (popPend) begin void'(stage.pop_front()); popPend = 0; end
      if (fill > 0 && ($urandom % 4) == 0) fill--;
      outFull    = (fill >= CAP);
      dnSpace    = SW'(CAP - fill);
      inRowReady = (stage.size() >= BPR);
      inData     = (stage.size() > 0) ? stage[0] : '0;
      memRdy     = ($urandom % 10) < 7;
      memWdfRdy  = ($urandom % 10) < 7;
      if (rdTimeQ.size() > 0 && rdTimeQ[0] <= cyc) begin
        memRdValid = 1'b1;
        memRdData  = rdDataQ.pop_front();
        void'(rdTimeQ.pop_front());
      end else begin
        memRdValid = 1'b0;
      end
      cond = calDone && inRowReady && ((pops / IMG_BEATS) - (rdLoads / IMG_BEATS) < SLOTS);
      #1;
      newCmd = memEn && (!prevEn || prevAcc);
      if (!calDone) tally(!newCmd, "R2", 64'(memEn), 64'd0);
      if (prevEn && !prevAcc)
        tally(memEn && memAddr == prevAddr && memCmd == prevCmd, "R3",
              64'(memAddr), 64'(prevAddr));
      if (newCmd && memCmd == CMD_READ) begin
        tally(!prevFull, "R9", 64'(prevFull), 64'd0);
        rdLoads++;
        if (prevCond) run++; else run = 0;
        tally(run <= BPR, "R7", 64'(run), 64'(BPR));
      end
      if (newCmd && memCmd == CMD_WRITE) begin
        tally(memWdfWren && memWdfEnd, "R11", {memWdfWren, memWdfEnd}, 64'd3);
        run = 0;
      end
      acc = memEn && memRdy;
      if (acc && memCmd == CMD_WRITE) begin
        tally(int'(memAddr) == wrNext, "R4", 64'(memAddr), 64'(wrNext));
        wrNext = (wrNext + 1) % REGION;
        wAddrQ.push_back(int'(memAddr));
      end
      if (acc && memCmd == CMD_READ) begin
        tally(int'(memAddr) == rdNext, "R4", 64'(memAddr), 64'(rdNext));
        rdNext = (rdNext + 1) % REGION;
        tally(stored / IMG_BEATS > rdAccCnt / IMG_BEATS, "R6",
              64'(stored), 64'((rdAccCnt / IMG_BEATS + 1) * IMG_BEATS));
        rdAccCnt++;
        a = int'(memAddr);
        rdDataQ.push_back(memArr.exists(a) ? memArr[a] : 'x);
        live[a] = 1'b0;
        t = cyc + 1 + int'($urandom % 6);
        if (t < lastRdTime) t = lastRdTime;
        lastRdTime = t;
        rdTimeQ.push_back(t);
      end
      if (memWdfWren && memWdfRdy) wDataQ.push_back(memWdfData);
      while (wAddrQ.size() > 0 && wDataQ.size() > 0) begin
        a = wAddrQ.pop_front();
        tally(!(live.exists(a) && live[a]), "R8", 64'(a), 64'd0);
        memArr[a] = wDataQ.pop_front();
        live[a] = 1'b1;
        stored++;
      end
      if (inPop) begin pops++; popPend = 1; end
      if (outValid) begin
        e = (expQ.size() > 0) ? expQ.pop_front() : 'x;
        tally(outData === e, "R5", outData, e);
        received++;
        fill++;
        tally(fill <= CAP, "R10", 64'(fill), 64'(CAP));
      end
      prevEn = memEn; prevAcc = acc; prevAddr = memAddr; prevCmd = memCmd;
      prevFull = outFull; prevCond = cond;
      cyc++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    tally(!memEn, "R1", 64'(memEn), 64'd0);
    tally(!memWdfWren, "R1", 64'(memWdfWren), 64'd0);
    tally(!inPop, "R1", 64'(inPop), 64'd0);
    tally(!outValid, "R1", 64'(outValid), 64'd0);
    rstN = 1'b1;
    // R2: rows wait while calibration is pending
    repeat (3) pushRow();
    repeat (20) @(negedge clk);
    calDone = 1'b1;
    // burst fills both image slots, then a trickle
    for (int r = 3; r < TOTAL_ROWS; r++) begin
      if (r >= 8) repeat ($urandom % 30) @(posedge clk);
      @(posedge clk);
      #2;
      pushRow();
    end
    while (received < TOTAL_ROWS * BPR && cyc < LIMIT) @(posedge clk);
    if (cyc >= LIMIT) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", received, TOTAL_ROWS * BPR);
    end
    repeat (10) @(posedge clk);
    tally(expQ.size() == 0 && received == TOTAL_ROWS * BPR, "R5",
          64'(received), 64'(TOTAL_ROWS * BPR));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule